// File: doc/BRIEF.md
# Trigger-Captured Linear Resampler

This block lives at a node that produces signed samples on its own local strobe. A second node, clocked independently, sends a trigger pulse at each moment it takes a sample of its own. For every trigger, the block measures how far into the current local sample period the trigger fell. It then returns one value linearly interpolated between the two newest local samples, so the consumer receives exactly one value per tick of its own clock. The small rate offset between the two nodes (tens of ppm) makes the trigger phase sweep slowly across the local period, and the block keeps the stream consistent through that sweep.

The trigger is asynchronous and passes through a flop synchronizer with edge detection. The local strobe and data are delayed by the same number of stages, so the synchronizer latency cancels out of the elapsed-time measurement. The weight is the elapsed cycle count times a precomputed reciprocal of the period. The block always interpolates between the previous and the newest sample rather than extrapolating past the newest one. This costs one local period of delay.

Top module: `trig_resampler`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `res_valid`, `overrun` and `res_data` are all zero.
- R2: Each rising edge of `trig_in` seen at clock edge E produces exactly one single-cycle `res_valid` pulse, registered at clock edge E+4. No other `res_valid` pulses occur.
- R3: The elapsed time t is E minus the clock edge at which `smp_stb` was last sampled high before E, in whole clock cycles, saturated at TS_CYC-1. It is also TS_CYC-1 when no strobe has occurred since reset.
- R4: The weight is frac = (t*K) >> 8 on FRAC_W bits, where K = ceil(2^(FRAC_W+8)/TS_CYC).
- R5: With p the older sample and c the newer sample of the pair, the result is p + ((c-p)*frac + 2^(FRAC_W-1)) >>> FRAC_W (rounded to nearest, ties upward), saturated to the signed DATA_W range. The result never lies outside [min(p,c), max(p,c)].
- R6: A trigger sampled at the same clock edge as a strobe uses the sample pair and strobe time from before that strobe.
- R7: Several triggers with no strobe between them all use the same sample pair, each with its own t.
- R8: A trigger edge at E whose predecessor was at E-2 raises `overrun` for one cycle, registered at edge E+2. Both triggers still get their results. A spacing of 3 or more edges never raises `overrun`.
- R9: A trigger held high for many cycles yields a single result; only the rising edge counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Local sample strobe, one cycle per local sample |
| smp_data | input | DATA_W | Signed local sample, valid with `smp_stb` |
| trig_in | input | 1 | Asynchronous trigger from the consuming node |
| res_valid | output | 1 | One-cycle pulse per trigger |
| res_data | output | DATA_W | Signed interpolated result |
| overrun | output | 1 | Pulse: trigger arrived while the previous one was still in flight |

## Verification
The hardest case to reach is the moment when the trigger and the local strobe fall on the same clock edge, together with the edges just before and after it. This is where the choice of sample pair flips and t jumps from TS_CYC-1 to 0. The stimulus reproduces the slow drift by giving the triggers a period one cycle longer than the strobe period. Over one full sweep every phase is visited once, and exactly one trigger coincides with a strobe. Further stimulus covers a strobe outage that saturates t, several triggers inside one period, trigger bursts spaced two and three cycles apart, and a trigger level held high.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;
  // guard bits kept below the fraction when forming t * (1/Ts)
  localparam int GUARD_W = 8;

  // ceil(2^(fw+GUARD_W) / ts)
  function automatic longint recip(input int ts, input int fw);
    longint num;
    num = longint'(1) <<< (fw + GUARD_W);
    return (num + longint'(ts) - 1) / longint'(ts);
  endfunction
endpackage

// File: rtl/rsmp_trig_sync.sv
module rsmp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain[0] <= trig_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      last <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/rsmp_sample_track.sv
module rsmp_sample_track #(
  parameter int DATA_W = 16,
  parameter int TS_CYC = 40,
  parameter int DELAY  = 2,
  parameter int T_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb_in,
  input  logic signed [DATA_W-1:0] dat_in,
  output logic signed [DATA_W-1:0] x_prev,
  output logic signed [DATA_W-1:0] x_cur,
  output logic [T_W-1:0]           since
);
  localparam logic [T_W-1:0] T_MAX = T_W'(TS_CYC - 1);

  // strobe and data delayed by the synchronizer depth so both paths align
  logic                     dstb [1:DELAY];
  logic signed [DATA_W-1:0] ddat [1:DELAY];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= DELAY; i++) begin
        dstb[i] <= 1'b0;
        ddat[i] <= '0;
      end
    end else begin
      dstb[1] <= stb_in;
      ddat[1] <= dat_in;
      for (int i = 2; i <= DELAY; i++) begin
        dstb[i] <= dstb[i-1];
        ddat[i] <= ddat[i-1];
      end
    end
  end

  // pair update and elapsed-time counter, restarted at the strobe edge
  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= '0;
      x_cur  <= '0;
      since  <= T_MAX;
    end else if (dstb[DELAY]) begin
      x_prev <= x_cur;
      x_cur  <= ddat[DELAY];
      since  <= T_W'(1);
    end else if (since != T_MAX) begin
      since  <= since + T_W'(1);
    end
  end
endmodule

// File: rtl/rsmp_interp.sv
module rsmp_interp #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 12,
  parameter int TS_CYC = 40,
  parameter int T_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rise,
  input  logic [T_W-1:0]           since,
  input  logic signed [DATA_W-1:0] x_prev,
  input  logic signed [DATA_W-1:0] x_cur,
  output logic                     res_valid,
  output logic signed [DATA_W-1:0] res_data,
  output logic                     overrun
);
  import rsmp_pkg::*;

  localparam int RW = FRAC_W + GUARD_W + 1;
  localparam int MW = T_W + RW;
  localparam int PW = DATA_W + FRAC_W + 2;
  localparam logic [RW-1:0] K = RW'(recip(TS_CYC, FRAC_W));
  localparam logic signed [PW-1:0] MAXV = PW'((longint'(1) <<< (DATA_W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = PW'(-(longint'(1) <<< (DATA_W-1)));
  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) <<< (FRAC_W-1));

  // stage A: capture
  logic                     va;
  logic [T_W-1:0]           ta;
  logic signed [DATA_W-1:0] pa, ca;
  // stage B: weight and difference
  logic                     vb;
  logic [FRAC_W-1:0]        frac_b;
  logic signed [DATA_W-1:0] base_b;
  logic signed [DATA_W:0]   diff_b;

  logic [MW-1:0] mul;
  assign mul = MW'(ta) * MW'(K);

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0; ta <= '0; pa <= '0; ca <= '0;
      vb <= 1'b0; frac_b <= '0; base_b <= '0; diff_b <= '0;
      overrun <= 1'b0;
    end else begin
      va <= rise;
      overrun <= rise & (va | vb);
      if (rise) begin
        ta <= since;
        pa <= x_prev;
        ca <= x_cur;
      end
      vb <= va;
      if (va) begin
        frac_b <= FRAC_W'(mul >> GUARD_W);
        base_b <= pa;
        diff_b <= {ca[DATA_W-1], ca} - {pa[DATA_W-1], pa};
      end
    end
  end

  // stage C: weighted sum, rounding, saturation
  logic signed [PW-1:0] diff_x, frac_x, prod, step, sum;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    diff_x = {{(PW-DATA_W-1){diff_b[DATA_W]}}, diff_b};
    frac_x = {{(PW-FRAC_W){1'b0}}, frac_b};
    prod   = diff_x * frac_x;
    step   = (prod + HALF) >>> FRAC_W;
    sum    = {{(PW-DATA_W){base_b[DATA_W-1]}}, base_b} + step;
    if (sum > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (sum < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= vb;
      if (vb) res_data <= sat;
    end
  end
endmodule

// File: rtl/trig_resampler.sv
module trig_resampler #(
  parameter int DATA_W      = 16,
  parameter int FRAC_W      = 12,
  parameter int TS_CYC      = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic                     trig_in,
  output logic                     res_valid,
  output logic signed [DATA_W-1:0] res_data,
  output logic                     overrun
);
  localparam int T_W = $clog2(TS_CYC);

  logic                     trig_rise;
  logic [T_W-1:0]           since_t;
  logic signed [DATA_W-1:0] pair_old, pair_new;

  rsmp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .trig_in(trig_in), .rise(trig_rise)
  );

  rsmp_sample_track #(
    .DATA_W(DATA_W), .TS_CYC(TS_CYC), .DELAY(SYNC_STAGES), .T_W(T_W)
  ) u_track (
    .clk(clk), .rst(rst), .stb_in(smp_stb), .dat_in(smp_data),
    .x_prev(pair_old), .x_cur(pair_new), .since(since_t)
  );

  rsmp_interp #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .TS_CYC(TS_CYC), .T_W(T_W)
  ) u_interp (
    .clk(clk), .rst(rst), .rise(trig_rise), .since(since_t),
    .x_prev(pair_old), .x_cur(pair_new),
    .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
  );
endmodule

// File: rtl/trig_resampler_chk.sv
module trig_resampler_chk #(
  parameter int DATA_W = 16,
  parameter int TS_CYC = 40,
  parameter int T_W    = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     trig_rise,
  input logic [T_W-1:0]           since_t,
  input logic signed [DATA_W-1:0] pair_old,
  input logic signed [DATA_W-1:0] pair_new,
  input logic                     res_valid,
  input logic signed [DATA_W-1:0] res_data,
  input logic                     overrun
);
  // R2: every result traces back to exactly one synchronized edge
  a_r2_has_cause: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(trig_rise, 3));
  a_r2_follows: assert property (@(posedge clk) disable iff (rst)
    trig_rise |-> ##3 res_valid);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R3: elapsed time never exceeds one period minus one
  a_r3_t_bound: assert property (@(posedge clk) disable iff (rst)
    since_t <= T_W'(TS_CYC - 1));
  // R5: result lies between the two samples captured with the trigger
  a_r5_lower: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data >= $past(pair_old, 3) || res_data >= $past(pair_new, 3)));
  a_r5_upper: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data <= $past(pair_old, 3) || res_data <= $past(pair_new, 3)));
  // R8: overrun is a single pulse tied to a fresh edge
  a_r8_cause: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(trig_rise));
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    overrun |=> !overrun);
endmodule

bind trig_resampler trig_resampler_chk #(
  .DATA_W(DATA_W), .TS_CYC(TS_CYC), .T_W(T_W)
) u_chk (
  .clk(clk), .rst(rst), .trig_rise(trig_rise), .since_t(since_t),
  .pair_old(pair_old), .pair_new(pair_new),
  .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
);

// File: tb/trig_resampler_bench.sv
`timescale 1ns/1ps
module trig_resampler_bench;
  localparam int DW = 16;
  localparam int FW = 12;
  localparam int TS = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic trig_in = 1'b0;
  logic signed [DW-1:0] smp_data = '0;
  logic res_valid, overrun;
  logic signed [DW-1:0] res_data;

  trig_resampler #(.DATA_W(DW), .FRAC_W(FW), .TS_CYC(TS), .SYNC_STAGES(2)) u_trig_resampler (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data), .trig_in(trig_in),
    .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int n_out = 0;
  longint edge_n = 0;
  always @(posedge clk) edge_n <= edge_n + 1;

  // reference state
  longint s_last = -1000;
  longint last_trg = -1000;
  int xp = 0, xc = 0;
  bit prev_trg = 1'b0;
  string cur_tag = "R5";

  longint q_edge[$];
  int     q_val[$];
  string  q_tag[$];
  bit     ovr_exp[longint];

  function automatic int model_y(input longint t, input int p, input int c);
    longint k, f, y;
    k = ((longint'(1) <<< (FW + 8)) + TS - 1) / TS;
    f = (t * k) >>> 8;
    y = longint'(p) + (((longint'(c) - p) * f + (longint'(1) <<< (FW - 1))) >>> FW);
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // driver: one call per clock cycle, the model follows the upcoming edge
  task automatic cyc(input bit stb, input int d, input bit trg);
    longint e, t;
    string tg;
    @(negedge clk);
    smp_stb  = stb;
    smp_data = DW'(d);
    trig_in  = trg;
    e = edge_n + 1;
    if (trg && !prev_trg) begin
      t = e - s_last;
      tg = cur_tag;
      if (t > TS - 1) begin t = TS - 1; tg = {cur_tag, " R3 saturated"}; end
      if (stb) tg = "R6 coincident";
      q_edge.push_back(e + 4);
      q_val.push_back(model_y(t, xp, xc));
      q_tag.push_back(tg);
      if (e - last_trg <= 2) ovr_exp[e + 2] = 1'b1;
      last_trg = e;
    end
    prev_trg = trg;
    if (stb) begin
      s_last = e;
      xp = xc;
      xc = int'(DW'(d) ^ 16'h0) - ((d[DW-1]) ? 65536 : 0);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        n_out++;
        if (q_edge.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 extra result: actual %0d expected none", res_data);
        end else begin
          longint ee; int ev; string et;
          ee = q_edge.pop_front(); ev = q_val.pop_front(); et = q_tag.pop_front();
          check({"R2 latency ", et}, edge_n, ee);
          check(et, longint'(res_data), longint'(ev));
        end
      end
      if (overrun || ovr_exp.exists(edge_n))
        check("R8 overrun", longint'(overrun), longint'(ovr_exp.exists(edge_n)));
    end
  end

  function automatic int rnd16();
    logic signed [15:0] v;
    v = 16'($urandom);
    return int'(v);
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int base_out;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 res_valid", res_valid, 0);
    check("R1 overrun", overrun, 0);
    check("R1 res_data", res_data, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 res_valid after release", res_valid, 0);
    check("R1 res_data after release", res_data, 0);

    // R3 R4 R5 R6: drifting sweep, trigger period one cycle longer
    cur_tag = "R4 R5 sweep";
    for (int k = 0; k < TS * 46; k++)
      cyc((k % TS) == 0, rnd16(), (k % (TS + 1)) == 7);

    // R3: strobe outage, t saturates
    cur_tag = "R3 outage";
    for (int k = 0; k < 160; k++) cyc(1'b0, 0, (k % 37) == 3);

    // R7 and extreme values: three triggers per period
    cur_tag = "R7 same pair";
    for (int k = 0; k < TS * 6; k++)
      cyc((k % TS) == 0, ((k / TS) % 2) ? 32767 : -32768,
          (k % TS) == 3 || (k % TS) == 12 || (k % TS) == 30);

    // R8: spacing two gives overrun, spacing three does not
    cur_tag = "R8 burst";
    cyc(1'b1, 1234, 1'b0);
    cyc(1'b0, 0, 1'b1); cyc(1'b0, 0, 1'b0); cyc(1'b0, 0, 1'b1); cyc(1'b0, 0, 1'b0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 0, 1'b0);
    cyc(1'b1, -999, 1'b0);
    cyc(1'b0, 0, 1'b1); cyc(1'b0, 0, 1'b0); cyc(1'b0, 0, 1'b0); cyc(1'b0, 0, 1'b1);
    for (int k = 0; k < 10; k++) cyc(1'b0, 0, 1'b0);

    // R9: held trigger
    cur_tag = "R9 held";
    base_out = n_out;
    cyc(1'b1, 500, 1'b0);
    for (int k = 0; k < 25; k++) cyc(k == 12, 700, 1'b1);
    for (int k = 0; k < 10; k++) cyc(1'b0, 0, 1'b0);
    check("R9 single result for held level", n_out - base_out, 1);

    for (int k = 0; k < 20; k++) cyc(1'b0, 0, 1'b0);
    check("R2 no missing results", q_edge.size(), 0);
    summary();
  end
endmodule